// File: doc/BRIEF.md
# Time-Division Serial Channel Port

This block connects a device to a 2048 kbit/s time-division serial stream. A frame holds 32 channels of 8 bits each. Only the first four channels belong to the device. The block is clocked at twice the bit rate, so each bit cell lasts two clock periods and a frame lasts 512 clocks. An active-low frame pulse aligns the timing base. After alignment the block does two things in the four owned channel slots:

- It assembles the incoming bits into a 32-bit received word, which it hands on in one strobe once the fourth channel has finished.
- It drives the device's four outgoing bytes onto the output stream. Outside those slots the output enable is low, and the pad is then high-impedance.

The outgoing word is captured once per frame, at the frame boundary, so the bytes on the line always belong to a single snapshot. If the expected frame pulse does not arrive, the counter wraps by itself and raises a loss-of-alignment flag. The next pulse clears that flag. The meaning of the channel contents is left to the logic around the block.

Top module: `tdm_slot_port`

## Requirements
- R1: While reset is asserted and right after it, `ser_oe`, `rx_valid` and `lof` are 0 and `rx_bytes` is all zeros.
- R2: A clock edge that samples `frame_n` low moves the timing base to the first clock of channel 0, bit 7. Each bit then takes two clocks, and a frame takes 512 clocks.
- R3: `ser_oe` is 1 only during the first 64 clocks of an aligned frame (channels 0 to 3). It is 0 for the other 448 clocks, and it stays 0 before the first frame pulse after reset.
- R4: Bits go out most significant first. `tx_bytes[31:24]` is sent in channel 0, `[23:16]` in channel 1, `[15:8]` in channel 2 and `[7:0]` in channel 3.
- R5: `tx_bytes` is captured only on the frame-boundary edge, meaning either the edge that samples a frame pulse or the wrap edge. A change during a frame does not affect the line until the next frame.
- R6: `ser_in` is sampled on the second clock of each bit cell. The value present during the first clock has no effect.
- R7: `rx_valid` is a one-clock pulse in the clock after the edge that samples bit 0 of channel 3. In that same clock all of `rx_bytes` is updated, with channel 0 in `[31:24]` down to channel 3 in `[7:0]`.
- R8: Bits received in channels 4 to 31 leave `rx_bytes` unchanged.
- R9: If 512 clocks pass with no frame pulse, `lof` goes to 1 and the timing wraps to channel 0, bit 7 without a break. The next frame pulse clears `lof`.
- R10: A frame pulse that arrives before the expected count realigns the timing base at once. The following frame is then sent and received from the new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame synchronization pulse |
| ser_in | input | 1 | Serial input stream |
| tx_bytes | input | 32 | Outgoing bytes for channels 0 to 3 |
| ser_out | output | 1 | Serial output data |
| ser_oe | output | 1 | Output enable; pad is high-impedance when 0 |
| rx_bytes | output | 32 | Received bytes for channels 0 to 3 |
| rx_valid | output | 1 | One-clock strobe marking new `rx_bytes` |
| lof | output | 1 | Loss of frame alignment flag |

## Verification
The bench drives the opposite bit value during the first half of every received bit cell. A block that sampled on the wrong clock would then assemble the inverted word. It changes `tx_bytes` in the middle of a frame, which catches a design that forwards the live input instead of the frame snapshot as a corrupted tail in the current frame. It fills channels 4 to 31 with toggling data and re-reads `rx_bytes` at the end of the frame, so a shift register that keeps running past channel 3 would be seen. A missed pulse and a pulse arriving early test the wrap and `lof` behaviour, and the realignment: a counter that ignored the early pulse would put the next frame's bytes in the wrong slots.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  // Index of the bit cell within the frame for a clock count.
  function automatic int unsigned slot_bit_ordinal(int unsigned cnt, int unsigned halves);
    return cnt / halves;
  endfunction

  // True on the clock period of a bit cell where the input is sampled.
  function automatic bit slot_is_sample(int unsigned cnt, int unsigned halves);
    return (cnt % halves) == (halves - 1);
  endfunction

  // Channel number for a clock count.
  function automatic int unsigned slot_channel(int unsigned cnt, int unsigned halves,
                                               int unsigned ch_w);
    return cnt / (halves * ch_w);
  endfunction

endpackage

// File: rtl/tdm_slot_timebase.sv
module tdm_slot_timebase #(
  parameter int FRAME_LEN = 512,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             locked_o,
  output logic             lof_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             locked;
  logic             lof;

  // Frame boundary: a pulse is sampled or the count wraps.
  assign load_o   = !frame_n || (cnt == LAST);
  assign cnt_o    = cnt;
  assign locked_o = locked;
  assign lof_o    = lof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
      lof    <= 1'b0;
    end else if (!frame_n) begin
      cnt    <= '0;
      locked <= 1'b1;
      lof    <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      lof <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int HALVES  = 2,
  parameter int ACT_LEN = 64,
  parameter int BUS_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             locked,
  input  logic             ser_in,
  output logic             sample_o,
  output logic [BUS_W-1:0] rx_bytes,
  output logic             rx_valid
);
  localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(ACT_LEN - 1);

  logic             in_act;
  logic             sample;
  logic             done;
  logic [BUS_W-1:0] shreg;
  logic [BUS_W-1:0] nxt;

  assign in_act   = (cnt <= ACT_LAST);
  assign sample   = in_act && slot_is_sample(32'(cnt), HALVES);
  assign done     = sample && (cnt == ACT_LAST);
  assign nxt      = {shreg[BUS_W-2:0], ser_in};
  assign sample_o = sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_bytes <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done && locked;
      if (sample) shreg <= nxt;
      if (done && locked) rx_bytes <= nxt;
    end
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int HALVES = 2,
  parameter int CH_W   = 8,
  parameter int USE_CH = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              locked,
  input  logic              load,
  input  logic [BUS_W-1:0]  tx_bytes,
  output logic [USE_CH-1:0] chan_en_o,
  output logic              ser_out,
  output logic              ser_oe
);
  localparam int BIDX_W = $clog2(BUS_W);

  logic [BUS_W-1:0]  hold;
  logic [USE_CH-1:0] chan_en;
  logic [BIDX_W-1:0] bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (load) hold <= tx_bytes;
  end

  for (genvar k = 0; k < USE_CH; k++) begin : g_chan
    assign chan_en[k] = locked && (slot_channel(32'(cnt), HALVES, CH_W) == 32'(k));
  end

  assign bidx      = BIDX_W'(BUS_W - 1 - slot_bit_ordinal(32'(cnt), HALVES));
  assign ser_oe    = |chan_en;
  assign ser_out   = ser_oe & hold[bidx];
  assign chan_en_o = chan_en;
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int FRAME_CH = 32,
  parameter int USE_CH   = 4,
  parameter int CH_W     = 8,
  parameter int HALVES   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_n,
  input  logic                     ser_in,
  input  logic [USE_CH*CH_W-1:0]   tx_bytes,
  output logic                     ser_out,
  output logic                     ser_oe,
  output logic [USE_CH*CH_W-1:0]   rx_bytes,
  output logic                     rx_valid,
  output logic                     lof
);
  localparam int FRAME_LEN = FRAME_CH * CH_W * HALVES;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int ACT_LEN   = USE_CH * CH_W * HALVES;
  localparam int BUS_W     = USE_CH * CH_W;

  logic [CNT_W-1:0]  slot_cnt;
  logic              locked;
  logic              frame_load;
  logic              rx_sample;
  logic [USE_CH-1:0] chan_en;

  tdm_slot_timebase #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
    .cnt_o(slot_cnt), .locked_o(locked), .lof_o(lof), .load_o(frame_load)
  );

  tdm_slot_rx #(.CNT_W(CNT_W), .HALVES(HALVES), .ACT_LEN(ACT_LEN), .BUS_W(BUS_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .cnt(slot_cnt), .locked(locked), .ser_in(ser_in),
    .sample_o(rx_sample), .rx_bytes(rx_bytes), .rx_valid(rx_valid)
  );

  tdm_slot_tx #(.CNT_W(CNT_W), .HALVES(HALVES), .CH_W(CH_W), .USE_CH(USE_CH),
                .BUS_W(BUS_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .cnt(slot_cnt), .locked(locked), .load(frame_load),
    .tx_bytes(tx_bytes), .chan_en_o(chan_en), .ser_out(ser_out), .ser_oe(ser_oe)
  );
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
  parameter int FRAME_CH = 32,
  parameter int USE_CH   = 4,
  parameter int CH_W     = 8,
  parameter int HALVES   = 2
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         frame_n,
  input logic                                         ser_oe,
  input logic                                         rx_valid,
  input logic                                         lof,
  input logic                                         locked,
  input logic                                         rx_sample,
  input logic [USE_CH-1:0]                            chan_en,
  input logic [$clog2(FRAME_CH*CH_W*HALVES)-1:0]      slot_cnt
);
  localparam int FRAME_LEN = FRAME_CH * CH_W * HALVES;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int ACT_LEN   = USE_CH * CH_W * HALVES;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(ACT_LEN - 1);
  localparam logic [CNT_W-1:0] ACT_END  = CNT_W'(ACT_LEN);

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> slot_cnt == '0);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && slot_cnt != LAST) |=> slot_cnt == $past(slot_cnt) + 1'b1);

  p_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> (locked && slot_cnt <= ACT_LAST));

  p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));

  p_sample_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sample |-> slot_cnt <= ACT_LAST);

  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_strobe_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(frame_n)) |-> slot_cnt == ACT_END);

  p_lof_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && slot_cnt == LAST) |=> lof);

  p_lof_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lof);
endmodule

bind tdm_slot_port tdm_slot_port_chk #(
  .FRAME_CH(FRAME_CH), .USE_CH(USE_CH), .CH_W(CH_W), .HALVES(HALVES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_oe(ser_oe), .rx_valid(rx_valid),
  .lof(lof), .locked(locked), .rx_sample(rx_sample), .chan_en(chan_en),
  .slot_cnt(slot_cnt)
);

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic        ser_in;
  logic [31:0] tx_bytes;
  wire         ser_out;
  wire         ser_oe;
  wire  [31:0] rx_bytes;
  wire         rx_valid;
  wire         lof;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdm_slot_port dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_in(ser_in), .tx_bytes(tx_bytes),
    .ser_out(ser_out), .ser_oe(ser_oe), .rx_bytes(rx_bytes), .rx_valid(rx_valid), .lof(lof)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One frame; cycle k is the k-th clock after the aligning edge.
  task automatic run_frame(input logic [31:0] rxd, input logic [31:0] txexp,
                           input logic [31:0] tx_mid, input bit scramble, input bit noise,
                           input int stop_at, input bit pulse_end, input bit exp_lof,
                           input string rx_req);
    for (int k = 0; k < stop_at; k++) begin
      logic bitv;
      @(negedge clk);
      if (k == 0) chk(lof === exp_lof, "R9", "lof at frame start", 32'(lof), 32'(exp_lof));
      if (k < 64) begin
        chk(ser_oe === 1'b1, (k == 0) ? "R2" : "R3", "oe in owned slot", 32'(ser_oe), 32'd1);
        chk(ser_out === txexp[31 - k/2], (k < 16) ? "R4" : "R5", "tx bit",
            32'(ser_out), 32'(txexp[31 - k/2]));
      end else begin
        chk(ser_oe === 1'b0, (k == 64) ? "R2" : "R3", "oe outside slots", 32'(ser_oe), 32'd0);
      end
      if (k == 64) begin
        chk(rx_valid === 1'b1, "R7", "strobe", 32'(rx_valid), 32'd1);
        chk(rx_bytes === rxd, rx_req, "received word", rx_bytes, rxd);
      end else if (k < 64 || k == 65) begin
        chk(rx_valid === 1'b0, "R7", "no strobe", 32'(rx_valid), 32'd0);
      end
      if (k == stop_at - 1 && k > 100)
        chk(rx_bytes === rxd, "R8", "word held after idle slots", rx_bytes, rxd);
      if (k == 20) tx_bytes = tx_mid;
      frame_n = !(pulse_end && k == stop_at - 1);
      if (k < 64) begin
        bitv   = rxd[31 - k/2];
        ser_in = (scramble && (k % 2 == 0)) ? ~bitv : bitv;
      end else begin
        ser_in = noise ? (k[0] ^ k[3]) : 1'b0;
      end
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; frame_n = 1'b1; ser_in = 1'b0; tx_bytes = '0;
    repeat (3) @(negedge clk);
    chk(ser_oe === 1'b0, "R1", "oe in reset", 32'(ser_oe), 32'd0);
    chk(rx_valid === 1'b0, "R1", "strobe in reset", 32'(rx_valid), 32'd0);
    chk(lof === 1'b0, "R1", "lof in reset", 32'(lof), 32'd0);
    chk(rx_bytes === 32'd0, "R1", "rx word in reset", rx_bytes, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic test_unlocked();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(ser_oe === 1'b0, "R3", "oe before first pulse", 32'(ser_oe), 32'd0);
      ser_in = i[0];
    end
    tx_bytes = 32'hB469_1EC3;
    frame_n  = 1'b0;
  endtask

  task automatic test_basic();
    run_frame(32'h1234_5678, 32'hB469_1EC3, 32'hB469_1EC3, 1'b0, 1'b0, 512, 1'b1, 1'b0, "R7");
  endtask

  task automatic test_tx_snapshot();
    run_frame(32'hC3A5_0FF0, 32'hB469_1EC3, 32'h5CA3_F00F, 1'b0, 1'b1, 512, 1'b1, 1'b0, "R7");
  endtask

  task automatic test_half_sample_and_miss();
    run_frame(32'h8001_7E00, 32'h5CA3_F00F, 32'h5CA3_F00F, 1'b1, 1'b1, 512, 1'b0, 1'b0, "R6");
    run_frame(32'hDEAD_BEEF, 32'h5CA3_F00F, 32'h5CA3_F00F, 1'b0, 1'b0, 512, 1'b1, 1'b1, "R9");
  endtask

  task automatic test_early_pulse();
    run_frame(32'h0F1E_2D3C, 32'h5CA3_F00F, 32'h5CA3_F00F, 1'b0, 1'b0, 100, 1'b1, 1'b0, "R7");
    run_frame(32'h5A5A_A5A5, 32'h5CA3_F00F, 32'h5CA3_F00F, 1'b0, 1'b1, 512, 1'b1, 1'b0, "R10");
  endtask

  initial begin
    test_reset();
    test_unlocked();
    test_basic();
    test_tx_snapshot();
    test_half_sample_and_miss();
    test_early_pulse();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule